// File: doc/BRIEF.md
# Bus Status Event Encoder

This block sits on the PHY side of a PHY-to-link interface. It receives bus events as single-cycle pulses on a 7-bit event input: bus reset, arbitration reset gap (odd and even), cycle start (odd and even), subaction gap, and interface reset. It reports each event to the link layer as a one-cycle status word. The status word is a code on a 2-bit control bus plus a one-hot 8-bit data bus, where each data line stands for a single event.

Only one event may be shown per status cycle. Events that arrive together are therefore latched as pending flags and issued one per cycle, lowest index first, so bus reset wins. Events also wait while a receive data cycle is announced. Nothing is reported while the link interface is inactive. During that time only a pending bus reset is kept, so it can be reported once the interface is restored.

A bus reset report comes with a flush pulse, which cancels queued transfer requests and forces both phase flags to even. An interface-reset report is followed one cycle later by a reset pulse for the interface.

Top module: `bus_status_encoder`

## Requirements
- R1: Each issued event occupies exactly one clock cycle on the control and data buses. The report appears in the cycle after the event (or its release from pending) is accepted.
- R2: The data bus maps events to bits as follows: bit 0 bus reset, bit 1 odd arbitration gap, bit 2 even arbitration gap, bit 3 odd cycle start, bit 4 even cycle start, bit 5 subaction gap, bit 6 interface reset. Event input bit i maps to data bit i, and data bit 7 is always 0.
- R3: During a status cycle the control bus reads 2'b01 and exactly one data bit is set. Otherwise the control bus reads 2'b00 and the data bus reads 8'h00.
- R4: Simultaneous or waiting events are issued one per cycle, lowest bit index first.
- R5: When rx_hold_i is high, no status appears in the following cycle, and waiting events are kept.
- R6: When link_active_i is low, no status appears in the following cycle. Waiting and arriving events other than bus reset are discarded, and a bus reset is kept for later.
- R7: An interface-reset report is followed in the next cycle by a one-cycle pulse on if_reset_o. During the report cycle and the pulse cycle no new event is issued, and non-bus-reset events are discarded.
- R8: flush_o pulses in the same cycle as every bus reset report, and at no other time.
- R9: Synchronous reset clears all waiting events and drives the control bus, data bus, if_reset_o and flush_o to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_active_i | input | 1 | Link interface is active |
| rx_hold_i | input | 1 | Next cycle carries receive data; hold status |
| evt_i | input | 7 | Event pulses, bit index as in R2 |
| ctl_o | output | 2 | Control code: 01 status, 00 idle |
| dat_o | output | 8 | One-hot status data |
| if_reset_o | output | 1 | Interface reset pulse after an interface-reset report |
| flush_o | output | 1 | Cancel requests and force phases even (with bus reset report) |

## Verification
The checker evaluates the following on every cycle:
- one-hot data with a zero reserved bit while the control code says status;
- all-zero data when idle;
- silence in the cycle after link inactivity or a receive hold;
- the interface reset pulse following an interface-reset report;
- flush only alongside a bus reset report.

Some behaviours depend on history and can only be shown by the bench's vector sequence:
- the lowest-index-first order in which bursts of events are drained;
- retention of a bus reset across an inactive period while other events are dropped;
- the loss of events that arrive during the interface reset window.

// File: rtl/bse_pkg.sv
package bse_pkg;

    localparam int unsigned N_EVT  = 7;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned CTL_W  = 2;

    localparam logic [CTL_W-1:0] CTL_IDLE   = 2'b00;
    localparam logic [CTL_W-1:0] CTL_STATUS = 2'b01;

    typedef enum int unsigned {
        EV_BUS_RESET = 0,
        EV_ARB_ODD   = 1,
        EV_ARB_EVEN  = 2,
        EV_CYC_ODD   = 3,
        EV_CYC_EVEN  = 4,
        EV_SUB_GAP   = 5,
        EV_IF_RESET  = 6
    } evt_idx_e;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] dat;
    } status_word_t;

    // Mask of events that survive an inactive or resetting interface.
    function automatic logic [N_EVT-1:0] keep_mask();
        logic [N_EVT-1:0] m;
        m = '0;
        m[EV_BUS_RESET] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/bse_pending.sv
module bse_pending
    import bse_pkg::*;
#(
    parameter int unsigned NE = N_EVT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NE-1:0] evt_i,
    input  logic          link_active_i,
    input  logic          rx_hold_i,
    input  logic          block_i,
    output logic [NE-1:0] grant_o
);

    logic [NE-1:0] pend_q;
    logic [NE-1:0] cand;
    logic [NE-1:0] first;
    logic [NE:0]   seen;
    logic          may_issue;
    logic          drop;

    assign cand      = pend_q | evt_i;
    assign drop      = !link_active_i || block_i;
    assign may_issue = !drop && !rx_hold_i;

    // Lowest-index-first priority chain.
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < NE; i++) begin : g_prio
        assign first[i]  = cand[i] && !seen[i];
        assign seen[i+1] = seen[i] || cand[i];
    end

    assign grant_o = may_issue ? first : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (drop) begin
            pend_q <= cand & keep_mask();
        end else begin
            pend_q <= cand & ~grant_o;
        end
    end

endmodule

// File: rtl/bse_drive.sv
module bse_drive
    import bse_pkg::*;
#(
    parameter int unsigned NE = N_EVT,
    parameter int unsigned DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NE-1:0]    grant_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [DW-1:0]    dat_o,
    output logic             if_reset_o,
    output logic             flush_o,
    output logic             block_o
);

    localparam int unsigned RSV_W = DW - NE;

    status_word_t word_q;
    logic         ifr_q;
    logic         flush_q;
    logic         ifr_rpt;

    assign ifr_rpt = (word_q.ctl == CTL_STATUS) && word_q.dat[EV_IF_RESET];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '{ctl: CTL_IDLE, dat: '0};
            ifr_q   <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            if (|grant_i) begin
                word_q.ctl <= CTL_STATUS;
                word_q.dat <= {{RSV_W{1'b0}}, grant_i};
            end else begin
                word_q.ctl <= CTL_IDLE;
                word_q.dat <= '0;
            end
            flush_q <= grant_i[EV_BUS_RESET];
            ifr_q   <= ifr_rpt;
        end
    end

    assign ctl_o      = word_q.ctl;
    assign dat_o      = word_q.dat;
    assign if_reset_o = ifr_q;
    assign flush_o    = flush_q;
    assign block_o    = ifr_rpt || ifr_q;

endmodule

// File: rtl/bus_status_encoder.sv
module bus_status_encoder
    import bse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              link_active_i,
    input  logic              rx_hold_i,
    input  logic [N_EVT-1:0]  evt_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [DATA_W-1:0] dat_o,
    output logic              if_reset_o,
    output logic              flush_o
);

    logic [N_EVT-1:0] grant;
    logic             block;

    bse_pending #(.NE(N_EVT)) u_pend (
        .clk           (clk),
        .rst           (rst),
        .evt_i         (evt_i),
        .link_active_i (link_active_i),
        .rx_hold_i     (rx_hold_i),
        .block_i       (block),
        .grant_o       (grant)
    );

    bse_drive #(.NE(N_EVT), .DW(DATA_W)) u_drv (
        .clk        (clk),
        .rst        (rst),
        .grant_i    (grant),
        .ctl_o      (ctl_o),
        .dat_o      (dat_o),
        .if_reset_o (if_reset_o),
        .flush_o    (flush_o),
        .block_o    (block)
    );

endmodule

// File: rtl/bse_checker.sv
module bse_checker
    import bse_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              link_active_i,
    input logic              rx_hold_i,
    input logic [CTL_W-1:0]  ctl_o,
    input logic [DATA_W-1:0] dat_o,
    input logic              if_reset_o,
    input logic              flush_o
);

    p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_o == CTL_STATUS) |-> ($countones(dat_o) == 1 && !dat_o[DATA_W-1]));

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_o != CTL_STATUS) |-> (ctl_o == CTL_IDLE && dat_o == '0));

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !dat_o[DATA_W-1]);

    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        rx_hold_i |=> (ctl_o == CTL_IDLE));

    p_inactive_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !link_active_i |=> (ctl_o == CTL_IDLE));

    p_ifreset_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_o == CTL_STATUS && dat_o[EV_IF_RESET]) |=> if_reset_o);

    p_ifreset_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        if_reset_o |-> (ctl_o == CTL_IDLE) && !$past(if_reset_o));

    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> (ctl_o == CTL_STATUS && dat_o[EV_BUS_RESET]));

    p_flush_with_br_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_o == CTL_STATUS && dat_o[EV_BUS_RESET]) |-> flush_o);

endmodule

bind bus_status_encoder bse_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .link_active_i (link_active_i),
    .rx_hold_i     (rx_hold_i),
    .ctl_o         (ctl_o),
    .dat_o         (dat_o),
    .if_reset_o    (if_reset_o),
    .flush_o       (flush_o)
);

// File: tb/bus_status_encoder_test.sv
`timescale 1ns/1ps
module bus_status_encoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_active_i = 1'b0;
    logic       rx_hold_i = 1'b0;
    logic [6:0] evt_i = '0;
    logic [1:0] ctl_o;
    logic [7:0] dat_o;
    logic       if_reset_o;
    logic       flush_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_status_encoder uut (
        .clk(clk), .rst(rst), .link_active_i(link_active_i), .rx_hold_i(rx_hold_i),
        .evt_i(evt_i), .ctl_o(ctl_o), .dat_o(dat_o), .if_reset_o(if_reset_o), .flush_o(flush_o)
    );

    typedef struct packed {
        logic       link;
        logic       hold;
        logic [6:0] evt;
        logic [1:0] ctl;
        logic [7:0] dat;
        logic       ifr;
        logic       fl;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,7'b0000000,2'b00,8'h00,1'b0,1'b0}, //  0 idle
        '{1'b1,1'b0,7'b0001000,2'b01,8'h08,1'b0,1'b0}, //  1 single odd cycle start R1 R2
        '{1'b1,1'b0,7'b0110110,2'b01,8'h02,1'b0,1'b0}, //  2 burst, lowest first R4
        '{1'b1,1'b1,7'b0000000,2'b00,8'h00,1'b0,1'b0}, //  3 hold R5
        '{1'b1,1'b0,7'b0000001,2'b01,8'h01,1'b0,1'b1}, //  4 bus reset overtakes R4 R8
        '{1'b1,1'b0,7'b0000000,2'b01,8'h04,1'b0,1'b0}, //  5 drain
        '{1'b0,1'b0,7'b0000001,2'b00,8'h00,1'b0,1'b0}, //  6 inactive R6
        '{1'b0,1'b0,7'b0100000,2'b00,8'h00,1'b0,1'b0}, //  7 inactive, dropped R6
        '{1'b1,1'b0,7'b0000000,2'b01,8'h01,1'b0,1'b1}, //  8 bus reset kept R6
        '{1'b1,1'b0,7'b0000000,2'b00,8'h00,1'b0,1'b0}, //  9 others gone R6
        '{1'b1,1'b0,7'b1000100,2'b01,8'h04,1'b0,1'b0}, // 10
        '{1'b1,1'b0,7'b0000000,2'b01,8'h40,1'b0,1'b0}, // 11 interface reset report
        '{1'b1,1'b0,7'b0010000,2'b00,8'h00,1'b1,1'b0}, // 12 pulse R7
        '{1'b1,1'b0,7'b0000001,2'b00,8'h00,1'b0,1'b0}, // 13 blocked R7
        '{1'b1,1'b0,7'b0000000,2'b01,8'h01,1'b0,1'b1}, // 14 bus reset survived R7
        '{1'b1,1'b0,7'b1111111,2'b01,8'h01,1'b0,1'b1}, // 15 all events R4
        '{1'b1,1'b0,7'b0000000,2'b01,8'h02,1'b0,1'b0}, // 16
        '{1'b1,1'b0,7'b0000000,2'b01,8'h04,1'b0,1'b0}, // 17
        '{1'b1,1'b1,7'b0000000,2'b00,8'h00,1'b0,1'b0}, // 18 hold mid-burst R5
        '{1'b1,1'b0,7'b0000000,2'b01,8'h08,1'b0,1'b0}, // 19
        '{1'b1,1'b0,7'b0000000,2'b01,8'h10,1'b0,1'b0}, // 20
        '{1'b1,1'b0,7'b0000000,2'b01,8'h20,1'b0,1'b0}, // 21
        '{1'b1,1'b0,7'b0000000,2'b01,8'h40,1'b0,1'b0}, // 22
        '{1'b1,1'b0,7'b0000000,2'b00,8'h00,1'b1,1'b0}, // 23 pulse R7
        '{1'b1,1'b0,7'b0000000,2'b00,8'h00,1'b0,1'b0}  // 24 pulse one cycle R1
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got ctl/dat/ifr/fl=%h expected %h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset state", {ctl_o, dat_o, if_reset_o, flush_o}, 12'h000);
        @(negedge clk);
        rst = 1'b0;
        link_active_i = 1'b1;

        for (int i = 0; i < NV; i++) begin
            link_active_i = TBL[i].link;
            rx_hold_i     = TBL[i].hold;
            evt_i         = TBL[i].evt;
            @(posedge clk);
            #1;
            check($sformatf("R1-vec%0d R2 R3 R4 R5 R6 R7 R8", i),
                  {ctl_o, dat_o, if_reset_o, flush_o},
                  {TBL[i].ctl, TBL[i].dat, TBL[i].ifr, TBL[i].fl});
            @(negedge clk);
        end

        // R9: reset clears a retained bus reset and waiting events
        link_active_i = 1'b0;
        evt_i = 7'b0000011;
        @(negedge clk);
        evt_i = '0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R9 outputs in reset", {ctl_o, dat_o, if_reset_o, flush_o}, 12'h000);
        @(negedge clk);
        rst = 1'b0;
        link_active_i = 1'b1;
        @(posedge clk);
        #1;
        check("R9 pending cleared", {ctl_o, dat_o, if_reset_o, flush_o}, 12'h000);
        @(negedge clk);

        // R3 R2: subaction gap alone
        evt_i = 7'b0100000;
        @(posedge clk);
        #1;
        check("R2 subaction gap bit 5", {ctl_o, dat_o, if_reset_o, flush_o}, {2'b01, 8'h20, 2'b00});
        @(negedge clk);
        evt_i = '0;
        @(posedge clk);
        #1;
        check("R1 report lasts one cycle", {ctl_o, dat_o, if_reset_o, flush_o}, 12'h000);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule